// File: doc/BRIEF.md
# Host Word Byte-Parity Checker

This block guards the host side of a serial transmit path. Every 32-bit word offered by the host comes with four parity bits, one per byte. The block checks each byte against its parity bit under an odd-parity rule and raises a single registered error flag one clock after any word that fails. A data/ordered-set control flag travels with the word. A mode input can make the most significant parity bit cover that flag as well as the top byte.

Checking is switched off by an active-low enable. It is also bypassed in raw mode, where the word is sent on untouched. In both cases the error flag is held low. The flag changes only for words marked by the valid strobe. On any other cycle it returns low.

Top module: `word_parity_checker`

## Requirements
- R1: A synchronous active-high reset `rst` forces `par_err` to 0 at the next rising clock edge.
- R2: Parity bit i (`par_bits[i]`) covers data byte `data_word[8*i+7:8*i]`. A wrong bit in any one position, including position 0 or position 3, is reported.
- R3: The parity is odd. A lane is in error when the number of ones in its byte plus its parity bit is even.
- R4: When `fold_ctl` is 1, `par_bits[3]` covers `data_word[31:24]` together with `ctl_flag`. When `fold_ctl` is 0, `ctl_flag` has no effect on the result.
- R5: When `chk_en_n` is 1, `par_err` is 0 in the cycle after the word, whatever the parity.
- R6: When `raw_mode` is 1, `par_err` is 0 in the cycle after the word, whatever the parity.
- R7: When `in_valid` is 0, `par_err` is 0 in the following cycle.
- R8: `par_err` is the OR of the four lane checks. It is registered, so it appears one clock after the word and is refreshed on every clock.
- R9: When `ctl_flag` is 1 (an ordered-set word), all four bytes are still checked, including the low three.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks a word to be checked |
| data_word | input | 32 | Host transmit word |
| ctl_flag | input | 1 | 1 when the word is an ordered set |
| par_bits | input | 4 | One odd-parity bit per byte |
| chk_en_n | input | 1 | Checking enable, active low |
| fold_ctl | input | 1 | 1 to make the top parity bit cover `ctl_flag` |
| raw_mode | input | 1 | 1 to bypass checking |
| par_err | output | 1 | Registered parity-error flag |

## Verification
The assertions assume that every control input is a defined 0 or 1 at each rising edge. They also assume that `rst` is high at the first edge, so the error register starts from a known value. The bench meets both conditions. It drives all inputs at falling edges only, and it holds reset for several cycles before the first word. No input ever goes to X or Z during a run. The assertions need no other condition on the data, so the bench walks arbitrary patterns in the data and parity fields.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

    localparam int unsigned LANES_DEF  = 4;
    localparam int unsigned LANE_W_DEF = 8;

    typedef struct packed {
        logic valid;
        logic en_n;
        logic raw;
    } wpc_ctl_t;

    // Odd-parity test: returns 1 when the group of bits holds an even count (error).
    function automatic logic lane_even(input logic [LANE_W_DEF-1:0] b,
                                       input logic p,
                                       input logic extra);
        return ~(^{b, p, extra});
    endfunction

endpackage

// File: rtl/wpc_lane.sv
module wpc_lane #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] byte_in,
    input  logic         par_in,
    input  logic         extra_en,
    input  logic         extra_in,
    output logic         bad
);
    logic [wpc_pkg::LANE_W_DEF-1:0] ext;

    always_comb begin
        ext = '0;
        ext[W-1:0] = byte_in;
        bad = wpc_pkg::lane_even(ext, par_in, extra_en & extra_in);
    end
endmodule

// File: rtl/wpc_flag.sv
module wpc_flag #(
    parameter int unsigned N = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  wpc_pkg::wpc_ctl_t ctl,
    input  logic [N-1:0]      lane_bad,
    output logic              err_q
);
    logic active;

    always_comb active = ctl.valid & ~ctl.en_n & ~ctl.raw;

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= active & (|lane_bad);
    end

    // R8: a failing lane on an active word shows up one clock later
    assert_err_follows_R8: assert property (@(posedge clk) disable iff (rst)
        (active && lane_bad != '0) |=> err_q);
    // R8: a clean active word leaves the flag low
    assert_clean_word_R8: assert property (@(posedge clk) disable iff (rst)
        (active && lane_bad == '0) |=> !err_q);
endmodule

// File: rtl/word_parity_checker.sv
module word_parity_checker #(
    parameter int unsigned LANES  = wpc_pkg::LANES_DEF,
    parameter int unsigned LANE_W = wpc_pkg::LANE_W_DEF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [LANES*LANE_W-1:0] data_word,
    input  logic                    ctl_flag,
    input  logic [LANES-1:0]        par_bits,
    input  logic                    chk_en_n,
    input  logic                    fold_ctl,
    input  logic                    raw_mode,
    output logic                    par_err
);
    localparam int unsigned TOP_LANE = LANES - 1;

    logic [LANES-1:0]  lane_bad;
    wpc_pkg::wpc_ctl_t ctl;

    always_comb begin
        ctl.valid = in_valid;
        ctl.en_n  = chk_en_n;
        ctl.raw   = raw_mode;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        if (i == TOP_LANE) begin : g_top
            wpc_lane #(.W(LANE_W)) u_lane (
                .byte_in (data_word[i*LANE_W +: LANE_W]),
                .par_in  (par_bits[i]),
                .extra_en(fold_ctl),
                .extra_in(ctl_flag),
                .bad     (lane_bad[i])
            );
        end else begin : g_low
            wpc_lane #(.W(LANE_W)) u_lane (
                .byte_in (data_word[i*LANE_W +: LANE_W]),
                .par_in  (par_bits[i]),
                .extra_en(1'b0),
                .extra_in(1'b0),
                .bad     (lane_bad[i])
            );
        end
    end

    wpc_flag #(.N(LANES)) u_flag (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .lane_bad(lane_bad),
        .err_q   (par_err)
    );

    assert_reset_clears_R1: assert property (@(posedge clk) rst |=> !par_err);
    assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        chk_en_n |=> !par_err);
    assert_raw_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        raw_mode |=> !par_err);
    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !par_err);
endmodule

// File: tb/word_parity_checker_bench.sv
module word_parity_checker_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] data_word = '0;
    logic        ctl_flag = 1'b0;
    logic [3:0]  par_bits = '0;
    logic        chk_en_n = 1'b0;
    logic        fold_ctl = 1'b0;
    logic        raw_mode = 1'b0;
    logic        par_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    word_parity_checker u_word_parity_checker (
        .clk(clk), .rst(rst), .in_valid(in_valid), .data_word(data_word),
        .ctl_flag(ctl_flag), .par_bits(par_bits), .chk_en_n(chk_en_n),
        .fold_ctl(fold_ctl), .raw_mode(raw_mode), .par_err(par_err)
    );

    // valid, en_n, fold, raw, ctl, par[3:0], data[31:0], expected
    localparam int NV = 15;
    localparam logic [41:0] VEC [NV] = '{
        {5'b1_0_0_0_0, 4'hF, 32'h0000_0000, 1'b0}, // R3 all-zero word clean
        {5'b1_0_0_0_0, 4'hE, 32'h0000_0000, 1'b1}, // R2 lane 0 wrong
        {5'b1_0_0_0_0, 4'h7, 32'h0000_0000, 1'b1}, // R2 lane 3 wrong
        {5'b1_0_0_0_0, 4'h2, 32'h0102_0304, 1'b0}, // R3 mixed bytes clean
        {5'b1_0_0_0_0, 4'h3, 32'h0102_0304, 1'b1}, // R3 mixed, lane 0 even
        {5'b1_0_1_0_1, 4'hF, 32'h0000_0000, 1'b1}, // R4 flag folded -> even
        {5'b1_0_1_0_1, 4'h7, 32'h0000_0000, 1'b0}, // R4 flag folded -> odd
        {5'b1_0_0_0_1, 4'hF, 32'h0000_0000, 1'b0}, // R4 flag not folded
        {5'b1_1_0_0_0, 4'h0, 32'h0000_0000, 1'b0}, // R5 disabled
        {5'b1_0_0_1_0, 4'h0, 32'h0000_0000, 1'b0}, // R6 raw
        {5'b0_0_0_0_0, 4'h0, 32'h0000_0000, 1'b0}, // R7 not valid
        {5'b1_0_0_0_0, 4'h0, 32'hFFFF_FFFF, 1'b1}, // R8 all lanes bad
        {5'b1_0_0_0_0, 4'hF, 32'hFFFF_FFFF, 1'b0}, // R8 flag clears next word
        {5'b1_0_0_0_1, 4'h6, 32'hBC00_0001, 1'b0}, // R9 ordered set clean
        {5'b1_0_0_0_1, 4'h7, 32'hBC00_0001, 1'b1}  // R9 ordered set low byte bad
    };

    task automatic check(input logic exp, input string req);
        n_chk++;
        if (par_err !== exp) begin
            n_bad++;
            $display("FAIL %s: par_err actual=%b expected=%b", req, par_err, exp);
        end
    endtask

    task automatic drive(input logic [41:0] v);
        {in_valid, chk_en_n, fold_ctl, raw_mode, ctl_flag} = v[41:37];
        par_bits  = v[36:33];
        data_word = v[32:1];
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(1'b0, "R1 reset state");
        rst = 1'b0;
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            @(negedge clk);
            check(VEC[i][0], $sformatf("vector %0d", i));
        end
        // R1: reset while the flag is high
        drive({5'b1_0_0_0_0, 4'h0, 32'h0, 1'b1});
        @(negedge clk);
        check(1'b1, "R1 flag set before reset");
        rst = 1'b1;
        @(negedge clk);
        check(1'b0, "R1 reset clears flag");
        rst = 1'b0;
        // R5 and R6 combined with a bad word on every lane
        drive({5'b1_1_0_1_0, 4'h0, 32'hFFFF_FFFF, 1'b0});
        @(negedge clk);
        check(1'b0, "R5 R6 both bypass");
        // R2: each lane flipped alone
        for (int k = 0; k < 4; k++) begin
            drive({5'b1_0_0_0_0, 4'hF ^ (4'h1 << k), 32'h0, 1'b0});
            @(negedge clk);
            check(1'b1, $sformatf("R2 lane %0d alone", k));
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule